// File: doc/BRIEF.md
# PCI configuration address translator

This block is the configuration-access unit of a host bridge. The CPU sees two 4 KiB windows. The index window holds one 32-bit index register. The data window is where configuration reads and writes take place. Software writes a configuration pointer into the index register, then reads or writes the data window with byte, halfword or word accesses. On each data-window access the block combines the stored index with the low bits of the window offset. From these it forms a bus/device/function/register address and sends exactly one request to a downstream configuration backend.

Three index formats are decoded, with a fixed priority:
- **Pass-through**: selected when index bit 31 is set.
- **Type-1 style**: selected when index bit 0 is set.
- **One-hot select line (type-0)**: used otherwise. The lowest set bit among index bits 31:11 gives the device number.

Data lanes are little-endian. Write data is steered into the addressed byte lanes, and read data is brought back right-aligned. The block also folds per-device interrupt pins onto four shared interrupt outputs using the usual rotate-by-device rule.

Top module: `cfgx_bridge_top`

## Requirements
- R1: After reset the index register reads 0, `bk_valid` is 0 and `cpu_ready` is 0.
- R2: The index register takes the value of a write only when the write is word-sized (`cpu_size`=2). Byte (0) and halfword (1) writes to it leave it unchanged. A read returns the stored value.
- R3: When index bit 31 is 1, the backend address is the index with data-window offset bits 1:0 ORed in.
- R4: When index bit 31 is 0 and bit 0 is 1, the backend address is the index with bits 2:0 replaced by offset bits 2:0.
- R5: When index bits 31 and 0 are both 0, the backend address is formed field by field:
  - bits 31:16 are zero;
  - bits 15:11 hold the position of the lowest set bit among index bits 31:11;
  - bits 10:8 hold index bits 10:8;
  - bits 7:3 hold index bits 7:3;
  - bits 2:0 hold offset bits 2:0.
- R6: In the R5 format, when index bits 31:11 are all zero, address bits 15:11 are 31.
- R7: Let o be offset bits 1:0.
  - Byte enables are 0001<<o for a byte access, 0011<<o for a halfword access and 1111 for a word access.
  - `bk_wdata` is `cpu_wdata` shifted left by 8*o.
- R8: For a data-window read, `cpu_rdata` is `bk_rdata` shifted right by 8*o and masked to the access size.
- R9: The handshake works as follows:
  - One cycle after a data access is accepted, `bk_valid` rises with all request fields valid.
  - The request fields stay stable until a cycle in which `bk_ready` is 1.
  - In the next cycle `cpu_ready` pulses for exactly one cycle and `bk_valid` is 0.
- R10: `irq_out[k]` is the OR of every `pin_irq[4*i+p]` for which (p + DEV_BASE + i) mod 4 equals k. The output is combinational from the inputs.
- R11: `cpu_addr[12]`=0 selects the index window and `cpu_addr[12]`=1 selects the data window. An index-window access completes with `cpu_ready` one cycle after acceptance and issues no backend request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_addr | input | 13 | Bit 12 selects the window; bits 11:0 are the offset |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Right-aligned read data, valid with `cpu_ready` |
| bk_valid | output | 1 | Backend request valid |
| bk_addr | output | 32 | Translated configuration address |
| bk_be | output | 4 | Byte enables |
| bk_write | output | 1 | Backend write flag |
| bk_wdata | output | 32 | Lane-steered write data |
| bk_ready | input | 1 | Backend acknowledge |
| bk_rdata | input | 32 | Backend read word, valid with `bk_ready` |
| pin_irq | input | 32 | Per-device interrupt pins, four per device slot |
| irq_out | output | 4 | Shared interrupt outputs |

## Verification
The assertions assume the following about the inputs:
- The CPU holds `cpu_valid` and its fields steady until `cpu_ready`, and then drops it.
- Halfword accesses sit at even offsets and word accesses at offsets that are multiples of four.
- `cpu_size` never takes the value 3.
- `bk_ready` is raised only while `bk_valid` is 1.

The stimulus issues one access at a time through a single task that obeys these rules. The backend responder raises `bk_ready` only after it has seen the request, with a chosen latency of zero or more cycles.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int CFG_W  = 32;
    localparam int LANES  = CFG_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [CFG_W-1:0]    index;
        logic                bk_valid;
        logic [CFG_W-1:0]    bk_addr;
        logic [LANES-1:0]    bk_be;
        logic                bk_write;
        logic [CFG_W-1:0]    bk_wdata;
        logic [1:0]          lane;
        size_e               size;
        logic                resp;
        logic [CFG_W-1:0]    rdata;
    } ctl_s;

endpackage

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate #(
    parameter int SEL_LO = 11,
    parameter int SEL_HI = 31
) (
    input  logic [31:0] index,
    input  logic [2:0]  off,
    output logic [31:0] addr
);
    logic [4:0] dev;

    // lowest set bit of the one-hot select field; all ones when empty
    always_comb begin
        dev = '1;
        for (int b = SEL_HI; b >= SEL_LO; b--) begin
            if (index[b]) dev = 5'(b);
        end
    end

    always_comb begin
        if (index[31]) begin
            addr = {index[31:2], index[1:0] | off[1:0]};
        end else if (index[0]) begin
            addr = {index[31:3], off};
        end else begin
            addr = {16'h0000, dev, index[10:8], index[7:3], off};
        end
    end
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane
    import cfgx_pkg::*;
(
    input  logic [1:0]       req_off,
    input  size_e            req_size,
    input  logic [CFG_W-1:0] req_wdata,
    output logic [LANES-1:0] req_be,
    output logic [CFG_W-1:0] req_wlane,
    input  logic [1:0]       rsp_off,
    input  size_e            rsp_size,
    input  logic [CFG_W-1:0] rsp_word,
    output logic [CFG_W-1:0] rsp_align
);
    logic [CFG_W-1:0] rsp_mask;

    always_comb begin
        case (req_size)
            SZ_BYTE: req_be = 4'b0001 << req_off;
            SZ_HALF: req_be = 4'b0011 << req_off;
            default: req_be = 4'b1111;
        endcase
        req_wlane = req_wdata << {req_off, 3'b000};
    end

    always_comb begin
        case (rsp_size)
            SZ_BYTE: rsp_mask = 32'h0000_00FF;
            SZ_HALF: rsp_mask = 32'h0000_FFFF;
            default: rsp_mask = 32'hFFFF_FFFF;
        endcase
        rsp_align = (rsp_word >> {rsp_off, 3'b000}) & rsp_mask;
    end
endmodule

// File: rtl/cfgx_irq_route.sv
module cfgx_irq_route #(
    parameter int NDEV     = 8,
    parameter int DEV_BASE = 11
) (
    input  logic [NDEV*4-1:0] pin_irq,
    output logic [3:0]        irq_out
);
    localparam int NPIN = NDEV * 4;

    function automatic logic [NPIN-1:0] route_mask(input int k);
        logic [NPIN-1:0] m;
        m = '0;
        for (int i = 0; i < NDEV; i++) begin
            for (int p = 0; p < 4; p++) begin
                if (((p + DEV_BASE + i) % 4) == k) m[i*4+p] = 1'b1;
            end
        end
        return m;
    endfunction

    for (genvar k = 0; k < 4; k++) begin : g_line
        localparam logic [NPIN-1:0] MASK = route_mask(k);
        assign irq_out[k] = |(pin_irq & MASK);
    end
endmodule

// File: rtl/cfgx_bridge_top.sv
module cfgx_bridge_top
    import cfgx_pkg::*;
#(
    parameter int WIN_BITS = 12,
    parameter int NDEV     = 8,
    parameter int DEV_BASE = 11,
    localparam int AW      = WIN_BITS + 1,
    localparam int NPIN    = NDEV * 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_write,
    input  logic [1:0]       cpu_size,
    input  logic [CFG_W-1:0] cpu_wdata,
    output logic             cpu_ready,
    output logic [CFG_W-1:0] cpu_rdata,
    output logic             bk_valid,
    output logic [CFG_W-1:0] bk_addr,
    output logic [LANES-1:0] bk_be,
    output logic             bk_write,
    output logic [CFG_W-1:0] bk_wdata,
    input  logic             bk_ready,
    input  logic [CFG_W-1:0] bk_rdata,
    input  logic [NPIN-1:0]  pin_irq,
    output logic [3:0]       irq_out
);
    ctl_s q, d;

    logic             data_win;
    logic             accept;
    size_e            req_size;
    logic [CFG_W-1:0] xl_addr;
    logic [LANES-1:0] req_be;
    logic [CFG_W-1:0] req_wlane;
    logic [CFG_W-1:0] rsp_align;
    logic [CFG_W-1:0] index_q;

    assign data_win = cpu_addr[WIN_BITS];
    assign req_size = size_e'(cpu_size);
    assign accept   = cpu_valid && (q.st == ST_IDLE) && !q.resp;
    assign index_q  = q.index;

    cfgx_addr_xlate u_xlate (
        .index (q.index),
        .off   (cpu_addr[2:0]),
        .addr  (xl_addr)
    );

    cfgx_lane u_lane (
        .req_off   (cpu_addr[1:0]),
        .req_size  (req_size),
        .req_wdata (cpu_wdata),
        .req_be    (req_be),
        .req_wlane (req_wlane),
        .rsp_off   (q.lane),
        .rsp_size  (q.size),
        .rsp_word  (bk_rdata),
        .rsp_align (rsp_align)
    );

    cfgx_irq_route #(.NDEV(NDEV), .DEV_BASE(DEV_BASE)) u_irq (
        .pin_irq (pin_irq),
        .irq_out (irq_out)
    );

    always_comb begin
        d      = q;
        d.resp = 1'b0;
        if (accept) begin
            if (data_win) begin
                d.st       = ST_WAIT;
                d.bk_valid = 1'b1;
                d.bk_addr  = xl_addr;
                d.bk_be    = req_be;
                d.bk_write = cpu_write;
                d.bk_wdata = req_wlane;
                d.lane     = cpu_addr[1:0];
                d.size     = req_size;
            end else begin
                d.resp  = 1'b1;
                d.rdata = q.index;
                if (cpu_write && req_size == SZ_WORD) d.index = cpu_wdata;
            end
        end else if (q.st == ST_WAIT && bk_ready) begin
            d.st       = ST_IDLE;
            d.bk_valid = 1'b0;
            d.resp     = 1'b1;
            d.rdata    = q.bk_write ? '0 : rsp_align;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_ready = q.resp;
    assign cpu_rdata = q.rdata;
    assign bk_valid  = q.bk_valid;
    assign bk_addr   = q.bk_addr;
    assign bk_be     = q.bk_be;
    assign bk_write  = q.bk_write;
    assign bk_wdata  = q.bk_wdata;
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_valid,
    input logic        win_sel,
    input logic        cpu_write,
    input logic [1:0]  cpu_size,
    input logic        cpu_ready,
    input logic        bk_valid,
    input logic        bk_ready,
    input logic [31:0] bk_addr,
    input logic [3:0]  bk_be,
    input logic        bk_write,
    input logic [31:0] bk_wdata,
    input logic [31:0] index_q
);
    logic idle_take;
    assign idle_take = cpu_valid && !bk_valid && !cpu_ready;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bk_valid && !bk_ready |=> bk_valid && $stable(bk_addr) && $stable(bk_be)
                                   && $stable(bk_write) && $stable(bk_wdata)); // R9

    AST_ACK_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        bk_valid && bk_ready |=> cpu_ready && !bk_valid); // R9

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R9

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        bk_valid |-> ($countones(bk_be) == 1 || bk_be == 4'b0011
                      || bk_be == 4'b1100 || bk_be == 4'b1111)); // R7

    AST_IDX_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        idle_take && !win_sel |=> cpu_ready && !bk_valid); // R11

    AST_IDX_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        idle_take && !win_sel && cpu_write && cpu_size != 2'd2 |=> $stable(index_q)); // R2

    AST_DATA_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        idle_take && win_sel |=> bk_valid && !cpu_ready); // R9
endmodule

bind cfgx_bridge_top cfgx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .win_sel   (cpu_addr[WIN_BITS]),
    .cpu_write (cpu_write),
    .cpu_size  (cpu_size),
    .cpu_ready (cpu_ready),
    .bk_valid  (bk_valid),
    .bk_ready  (bk_ready),
    .bk_addr   (bk_addr),
    .bk_be     (bk_be),
    .bk_write  (bk_write),
    .bk_wdata  (bk_wdata),
    .index_q   (index_q)
);

// File: tb/sim_cfgx_bridge_top.sv
module sim_cfgx_bridge_top;
    localparam int NDEV     = 8;
    localparam int DEV_BASE = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic        cpu_write = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        bk_valid;
    logic [31:0] bk_addr;
    logic [3:0]  bk_be;
    logic        bk_write;
    logic [31:0] bk_wdata;
    logic        bk_ready = 1'b0;
    logic [31:0] bk_rdata = '0;
    logic [31:0] pin_irq = '0;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_idx = '0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    cfgx_bridge_top #(.NDEV(NDEV), .DEV_BASE(DEV_BASE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
        .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bk_valid(bk_valid), .bk_addr(bk_addr), .bk_be(bk_be),
        .bk_write(bk_write), .bk_wdata(bk_wdata),
        .bk_ready(bk_ready), .bk_rdata(bk_rdata),
        .pin_irq(pin_irq), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference model
    function automatic logic [31:0] ref_xlate(input logic [31:0] idx, input logic [2:0] off);
        int dev;
        if (idx[31]) return idx | {30'd0, off[1:0]};
        if (idx[0])  return (idx & 32'hFFFF_FFF8) | {29'd0, off};
        dev = 31;
        for (int b = 31; b >= 11; b--) if (idx[b]) dev = b;
        return (32'(dev) << 11) | (32'(idx[10:8]) << 8) | (idx & 32'h0000_00F8) | {29'd0, off};
    endfunction

    function automatic logic [3:0] ref_be(input logic [1:0] o, input logic [1:0] sz);
        int n;
        logic [3:0] m;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        m = '0;
        for (int i = 0; i < n; i++) m[(int'(o) + i) % 4] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] ref_read(input logic [31:0] w, input logic [1:0] o, input logic [1:0] sz);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            if (ref_be(o, sz)[i]) r[8*(i-int'(o)) +: 8] = w[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_irq(input logic [31:0] pins);
        logic [3:0] r;
        r = '0;
        for (int i = 0; i < NDEV; i++)
            for (int p = 0; p < 4; p++)
                if (pins[i*4+p]) r[(p + DEV_BASE + i) % 4] = 1'b1;
        return r;
    endfunction

    // R10: interrupt routing compared on every clock
    always @(posedge clk) begin
        if (rst_n) chk("R10 irq", 32'(irq_out), 32'(ref_irq(pin_irq)));
    end

    task automatic access(input logic win, input logic [11:0] off, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd, input int lat,
                          input logic [31:0] rdw, input string req,
                          output logic [31:0] res);
        logic [31:0] ea;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = {win, off}; cpu_size = sz;
        cpu_write = wr; cpu_wdata = wd;
        @(negedge clk);
        if (win) begin
            ea = ref_xlate(model_idx, off[2:0]);
            chk("R9 req valid", 32'(bk_valid), 32'd1);
            chk(req, bk_addr, ea);
            chk("R7 be", 32'(bk_be), 32'(ref_be(off[1:0], sz)));
            chk("R9 write flag", 32'(bk_write), 32'(wr));
            if (wr) chk("R7 wdata", bk_wdata, wd << (8 * int'(off[1:0])));
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk("R9 hold valid", 32'(bk_valid), 32'd1);
                chk("R9 hold addr", bk_addr, ea);
                chk("R9 no early resp", 32'(cpu_ready), 32'd0);
            end
            bk_ready = 1'b1; bk_rdata = rdw;
            @(negedge clk);
            bk_ready = 1'b0;
            chk("R9 resp", 32'(cpu_ready), 32'd1);
            chk("R9 drop", 32'(bk_valid), 32'd0);
            if (!wr) chk("R8 rdata", cpu_rdata, ref_read(rdw, off[1:0], sz));
        end else begin
            chk("R11 no req", 32'(bk_valid), 32'd0);
            chk("R11 resp", 32'(cpu_ready), 32'd1);
            if (!wr) chk("R2 readback", cpu_rdata, model_idx);
            if (wr && sz == 2'd2) model_idx = wd;
        end
        res = cpu_rdata;
        cpu_valid = 1'b0;
        @(negedge clk);
        chk("R9 pulse", 32'(cpu_ready), 32'd0);
    endtask

    task automatic set_idx(input logic [31:0] v);
        logic [31:0] r;
        access(1'b0, 12'h000, 2'd2, 1'b1, v, 0, 32'h0, "R2", r);
        access(1'b0, 12'h000, 2'd2, 1'b0, 32'h0, 0, 32'h0, "R2", r);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 ready", 32'(cpu_ready), 32'd0);
        chk("R1 valid", 32'(bk_valid), 32'd0);
        access(1'b0, 12'h000, 2'd2, 1'b0, 32'h0, 0, 32'h0, "R1", rd);
        chk("R1 index zero", rd, 32'h0);

        // R2: narrow writes ignored, word write taken
        set_idx(32'h8001_2340);
        access(1'b0, 12'h004, 2'd1, 1'b1, 32'h0000_FFFF, 0, 32'h0, "R2", rd);
        access(1'b0, 12'h000, 2'd0, 1'b1, 32'h0000_00AA, 0, 32'h0, "R2", rd);
        access(1'b0, 12'h000, 2'd2, 1'b0, 32'h0, 0, 32'h0, "R2", rd);
        chk("R2 narrow ignored", rd, 32'h8001_2340);

        // R3 pass-through, byte read at offset 3
        access(1'b1, 12'h003, 2'd0, 1'b0, 32'h0, 0, 32'hAABB_CCDD, "R3 addr", rd);
        chk("R8 byte lane3", rd, 32'h0000_00AA);
        // R3 with bit 0 also set: pass-through wins
        set_idx(32'h8000_0801);
        access(1'b1, 12'h006, 2'd1, 1'b0, 32'h0, 2, 32'h1122_3344, "R3 priority", rd);
        chk("R8 half hi", rd, 32'h0000_1122);

        // R4 type-1, halfword write at offset 6
        set_idx(32'h00A1_2B05);
        access(1'b1, 12'h006, 2'd1, 1'b1, 32'h0000_1234, 1, 32'h0, "R4 addr", rd);
        access(1'b1, 12'h000, 2'd2, 1'b0, 32'h0, 3, 32'hDEAD_BEEF, "R4 addr", rd);
        chk("R8 word", rd, 32'hDEAD_BEEF);

        // R5 type-0 single select line, function 5, register 0x3C
        set_idx(32'h0000_253C);
        access(1'b1, 12'h004, 2'd2, 1'b1, 32'hCAFE_F00D, 0, 32'h0, "R5 addr", rd);
        // R5 multiple lines: lowest wins (bits 20 and 15 -> device 15)
        set_idx(32'h0010_8310);
        access(1'b1, 12'h001, 2'd0, 1'b0, 32'h0, 0, 32'h5566_7788, "R5 lowest", rd);
        chk("R8 byte lane1", rd, 32'h0000_0077);
        access(1'b1, 12'h002, 2'd0, 1'b1, 32'h0000_005A, 0, 32'h0, "R5 lowest", rd);

        // R6 no select bit -> device 31
        set_idx(32'h0000_07A8);
        access(1'b1, 12'h007, 2'd0, 1'b0, 32'h0, 1, 32'h0102_0304, "R6 dev31", rd);
        chk("R8 byte lane3b", rd, 32'h0000_0001);
        access(1'b1, 12'hFF8, 2'd2, 1'b0, 32'h0, 0, 32'h0BAD_F00D, "R11 high offset", rd);

        // R10 interrupt patterns
        @(negedge clk); pin_irq = 32'h0000_0001;
        @(negedge clk); pin_irq = 32'h0000_0010;
        @(negedge clk); pin_irq = 32'h8000_0000;
        @(negedge clk); pin_irq = 32'h1248_0000;
        @(negedge clk); pin_irq = 32'hFFFF_FFFF;
        @(negedge clk); pin_irq = 32'h0000_0000;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule